// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the horizontal and vertical position of a raster of 342 cycles per line and 262 lines per frame. It decodes that position into sync, blanking, border and pixel-enable flags. Each line opens with a short right-border stretch. A blanking interval that holds the horizontal sync pulse follows, then a left-border stretch. Pixels run from column 86 to the end of the line. The frame has a selectable number of pixel rows, then border rows, then a three-row vertical sync band, then border rows up to the last row. The last row draws no pixels.

Two interrupt sources sit beside the counters. The frame interrupt fires at a programmable row and column and stays raised until a status-read pulse clears it. The line interrupt is a down-counter that steps once per pixel row. When it underflows it reloads from a programmable target and latches a pending flag, provided the interrupt is enabled. A downstream pixel pipeline uses the flags to decide when to draw and when to fetch. The interrupt outputs go to the host processor.

Top module: `raster_timer`

## Requirements
- R1: After reset `col` and `row` are 0. `col` increments every cycle from 0 to 341 and then wraps to 0. `row` increments each time `col` wraps, runs from 0 to 261 and then wraps to 0.
- R2: `blank` is high when `col` is in 15..72 or `row` is in 227..229. `hsync` is high exactly when `col` is in 28..53.
- R3: `vsync` is high exactly when `row` is in 227..229.
- R4: `pix_en` is high when `row` is below the active line count, `col` is 86 or more and `blank` is low. The `act_sel` encoding gives the active line count: 0 gives 192, 1 gives 224, 2 gives 240 and 3 gives 192.
- R5: `border` is high exactly when both `blank` and `pix_en` are low.
- R6: `frame_irq` rises in the cycle after `col` equals `fint_col` and `row` equals `fint_row`. A `status_rd` pulse clears it. If the set condition and `status_rd` coincide, the set wins. After reset the defaults are 193 and 4.
- R7: The line counter acts in the last column of each line. If that row is active, the counter decrements, or reloads from `lint_target` when it is already 0. If that row is not active, the counter loads `lint_target`. Reset loads `lint_target`.
- R8: An underflow while `lint_en` is 1 sets `line_irq`. An underflow while `lint_en` is 0 leaves `line_irq` unchanged. `lint_ack` clears `line_irq`, and a set in the same cycle wins over `lint_ack`.
- R9: During and directly after reset, `frame_irq` and `line_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_sel | input | 2 | Active line count select |
| fint_row | input | 9 | Row of the frame interrupt |
| fint_col | input | 9 | Column of the frame interrupt |
| status_rd | input | 1 | Status-read pulse; clears the frame interrupt |
| lint_en | input | 1 | Line interrupt enable |
| lint_target | input | 8 | Line counter reload value |
| lint_ack | input | 1 | Clears the pending line interrupt |
| col | output | 9 | Horizontal position |
| row | output | 9 | Vertical position |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking interval |
| border | output | 1 | Border colour region |
| pix_en | output | 1 | Pixel output region |
| frame_irq | output | 1 | Frame interrupt flag |
| line_irq | output | 1 | Line interrupt pending |

## Verification
The bench builds the block with its default parameters: a 342 by 262 raster, a 58-cycle blanking interval and a three-row sync band. This lets two full frames, and both row and column wraps, fit in the run. The first frame switches from 192 to 240 active rows partway through, so active rows overlap the sync band and blanking must win. The second frame uses 224 rows. A line target of 0 makes the counter underflow on every row. The stimulus also drives a status read in the same cycle as the frame interrupt set, drives acknowledges in line-end cycles, and holds the enable low for one window.

// File: rtl/raster_pkg.sv
// Shared helpers for the raster timing generator.
// Assumes the select code is two bits wide; code 3 falls back to 192 rows.
package raster_pkg;

    localparam int unsigned ROWS_SHORT = 192;
    localparam int unsigned ROWS_MID   = 224;
    localparam int unsigned ROWS_TALL  = 240;

    // Map the active line select code to a row count.
    function automatic int unsigned rows_for(input logic [1:0] sel);
        case (sel)
            2'd1:    return ROWS_MID;
            2'd2:    return ROWS_TALL;
            default: return ROWS_SHORT;
        endcase
    endfunction

endpackage

// File: rtl/raster_counters.sv
// Column and row counters of the raster.
// Assumes H_TOTAL and V_TOTAL fit in COL_W and ROW_W bits.
module raster_counters #(
    parameter int H_TOTAL = 342,
    parameter int V_TOTAL = 262,
    parameter int COL_W   = 9,
    parameter int ROW_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             line_end
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_TOTAL - 1);

    assign line_end = (col == COL_LAST);

    // Advance the column every cycle, and the row on each column wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (line_end) begin
            col <= '0;
            row <= (row == ROW_LAST) ? '0 : row + ROW_W'(1);
        end else begin
            col <= col + COL_W'(1);
        end
    end

    p_col_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        col <= COL_LAST);
    p_col_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> col == '0);
    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && row != ROW_LAST) |=> row == $past(row) + ROW_W'(1));
endmodule

// File: rtl/raster_decode.sv
// Decodes the position into sync, blanking, border and pixel flags.
// Assumes one blanking interval per line and a sync band in rows.
module raster_decode
    import raster_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int ROW_W     = 9,
    parameter int H_TOTAL   = 342,
    parameter int H_RBORDER = 15,
    parameter int H_BLANK   = 58,
    parameter int H_LBORDER = 13,
    parameter int HS_OFF    = 13,
    parameter int HS_LEN    = 26,
    parameter int VS_START  = 227,
    parameter int VS_LEN    = 3
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [1:0]       act_sel,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic             border,
    output logic             pix_en,
    output logic             active_row
);
    localparam int           PIX_FIRST = H_RBORDER + H_BLANK + H_LBORDER;
    localparam logic [COL_W:0] HB_S = (COL_W+1)'(H_RBORDER);
    localparam logic [COL_W:0] HB_E = (COL_W+1)'(H_RBORDER + H_BLANK);
    localparam logic [COL_W:0] HS_S = (COL_W+1)'(H_RBORDER + HS_OFF);
    localparam logic [COL_W:0] HS_E = (COL_W+1)'(H_RBORDER + HS_OFF + HS_LEN);
    localparam logic [COL_W:0] PX_S = (COL_W+1)'(PIX_FIRST);
    localparam logic [COL_W:0] PX_E = (COL_W+1)'(H_TOTAL);
    localparam logic [ROW_W:0] VS_S = (ROW_W+1)'(VS_START);
    localparam logic [ROW_W:0] VS_E = (ROW_W+1)'(VS_START + VS_LEN);

    logic [COL_W:0] c;
    logic [ROW_W:0] r;
    logic           hblank;

    // Region decode; blanking takes priority over pixels.
    always_comb begin
        c          = {1'b0, col};
        r          = {1'b0, row};
        hblank     = (c >= HB_S) && (c < HB_E);
        hsync      = (c >= HS_S) && (c < HS_E);
        vsync      = (r >= VS_S) && (r < VS_E);
        blank      = hblank || vsync;
        active_row = r < (ROW_W+1)'(rows_for(act_sel));
        pix_en     = active_row && (c >= PX_S) && (c < PX_E) && !blank;
        border     = !blank && !pix_en;
    end
endmodule

// File: rtl/frame_irq_unit.sv
// Sticky frame interrupt, set at a programmed position, cleared by a status read.
// Assumes a set and a clear in the same cycle resolve to set.
module frame_irq_unit #(
    parameter int COL_W = 9,
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] hit_col,
    input  logic [ROW_W-1:0] hit_row,
    input  logic             status_rd,
    output logic             irq
);
    logic hit;
    assign hit = (col == hit_col) && (row == hit_row);

    // Latch the flag on a position match and drop it on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (hit)       irq <= 1'b1;
        else if (status_rd) irq <= 1'b0;
    end

    p_fint_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !status_rd) |=> irq);
    p_fint_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col == hit_col && row == hit_row) |=> irq);
endmodule

// File: rtl/line_irq_unit.sv
// Line interrupt down-counter with reload target and pending flag.
// Assumes line_end marks the last column and active_row the current row type.
module line_irq_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic             active_row,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    input  logic             ack,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;
    logic             under;

    assign under = line_end && active_row && (cnt == '0);

    // Step the counter at each line end; reload on underflow or outside active rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= target;
        end else if (line_end) begin
            if (!active_row || under) cnt <= target;
            else                      cnt <= cnt - CNT_W'(1);
        end
    end

    // Hold the pending flag until acknowledged; a new underflow wins.
    always_ff @(posedge clk) begin
        if (!rst_n)           irq <= 1'b0;
        else if (under && en) irq <= 1'b1;
        else if (ack)         irq <= 1'b0;
    end

    p_lint_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    p_lint_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !active_row) |=> cnt == $past(target));
endmodule

// File: rtl/raster_timer.sv
// Top of the raster timing generator: counters, region decode, two interrupts.
// Assumes one clock per pixel column; colour output is handled elsewhere.
module raster_timer #(
    parameter int H_TOTAL   = 342,
    parameter int V_TOTAL   = 262,
    parameter int H_RBORDER = 15,
    parameter int H_BLANK   = 58,
    parameter int H_LBORDER = 13,
    parameter int HS_OFF    = 13,
    parameter int HS_LEN    = 26,
    parameter int VS_START  = 227,
    parameter int VS_LEN    = 3,
    parameter int CNT_W     = 8,
    parameter int COL_W     = $clog2(H_TOTAL),
    parameter int ROW_W     = $clog2(V_TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       act_sel,
    input  logic [ROW_W-1:0] fint_row,
    input  logic [COL_W-1:0] fint_col,
    input  logic             status_rd,
    input  logic             lint_en,
    input  logic [CNT_W-1:0] lint_target,
    input  logic             lint_ack,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic             border,
    output logic             pix_en,
    output logic             frame_irq,
    output logic             line_irq
);
    logic line_end;
    logic active_row;

    raster_counters #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .COL_W(COL_W), .ROW_W(ROW_W))
    u_cnt (.clk(clk), .rst_n(rst_n), .col(col), .row(row), .line_end(line_end));

    raster_decode #(.COL_W(COL_W), .ROW_W(ROW_W), .H_TOTAL(H_TOTAL), .H_RBORDER(H_RBORDER),
        .H_BLANK(H_BLANK), .H_LBORDER(H_LBORDER), .HS_OFF(HS_OFF), .HS_LEN(HS_LEN),
        .VS_START(VS_START), .VS_LEN(VS_LEN))
    u_dec (.col(col), .row(row), .act_sel(act_sel), .hsync(hsync), .vsync(vsync),
        .blank(blank), .border(border), .pix_en(pix_en), .active_row(active_row));

    frame_irq_unit #(.COL_W(COL_W), .ROW_W(ROW_W))
    u_fint (.clk(clk), .rst_n(rst_n), .col(col), .row(row), .hit_col(fint_col),
        .hit_row(fint_row), .status_rd(status_rd), .irq(frame_irq));

    line_irq_unit #(.CNT_W(CNT_W))
    u_lint (.clk(clk), .rst_n(rst_n), .line_end(line_end), .active_row(active_row),
        .en(lint_en), .target(lint_target), .ack(lint_ack), .irq(line_irq));

    p_vsync_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> blank);
    p_pix_noblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> !blank);
    p_border_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({blank, border, pix_en}));
    p_hsync_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> blank);
endmodule

// File: tb/sim_raster_timer.sv
// Behavioural reference model of the raster timer, compared on every cycle.
module sim_raster_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] act_sel = 2'd0;
    logic [8:0] fint_row = 9'd193;
    logic [8:0] fint_col = 9'd4;
    logic       status_rd = 1'b0;
    logic       lint_en = 1'b1;
    logic [7:0] lint_target = 8'd2;
    logic       lint_ack = 1'b0;
    logic [8:0] col, row;
    logic       hsync, vsync, blank, border, pix_en, frame_irq, line_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_col, m_row, m_cnt;
    bit m_fint, m_pend;

    raster_timer u0 (.clk(clk), .rst_n(rst_n), .act_sel(act_sel), .fint_row(fint_row),
        .fint_col(fint_col), .status_rd(status_rd), .lint_en(lint_en),
        .lint_target(lint_target), .lint_ack(lint_ack), .col(col), .row(row),
        .hsync(hsync), .vsync(vsync), .blank(blank), .border(border), .pix_en(pix_en),
        .frame_irq(frame_irq), .line_irq(line_irq));

    always #10 clk = ~clk;

    function automatic int rows_of(input logic [1:0] s);
        return (s == 2'd1) ? 224 : (s == 2'd2) ? 240 : 192;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at model col %0d row %0d: actual %0d expected %0d",
                     req, m_col, m_row, act, exp);
        end
    endtask

    // Compare every output against the model state of this cycle.
    task automatic compare_all();
        bit e_vs, e_bl, e_pix;
        e_vs  = (m_row >= 227 && m_row <= 229);
        e_bl  = (m_col >= 15 && m_col <= 72) || e_vs;
        e_pix = (m_row < rows_of(act_sel)) && (m_col >= 86) && !e_bl;
        check("R1 col", int'(col), m_col);
        check("R1 row", int'(row), m_row);
        check("R2 hsync", int'(hsync), int'(m_col >= 28 && m_col <= 53));
        check("R2 blank", int'(blank), int'(e_bl));
        check("R3 vsync", int'(vsync), int'(e_vs));
        check("R4 pix_en", int'(pix_en), int'(e_pix));
        check("R5 border", int'(border), int'(!e_bl && !e_pix));
        check("R6 frame_irq", int'(frame_irq), int'(m_fint));
        check("R7 R8 line_irq", int'(line_irq), int'(m_pend));
    endtask

    // Advance the model through one clock edge using the inputs now applied.
    task automatic step_model();
        bit set;
        set = 1'b0;
        if (m_col == int'(fint_col) && m_row == int'(fint_row)) m_fint = 1'b1;
        else if (status_rd) m_fint = 1'b0;
        if (m_col == 341) begin
            if (m_row < rows_of(act_sel)) begin
                if (m_cnt == 0) begin
                    m_cnt = int'(lint_target);
                    set = lint_en;
                end else m_cnt = m_cnt - 1;
            end else m_cnt = int'(lint_target);
        end
        if (set) m_pend = 1'b1;
        else if (lint_ack) m_pend = 1'b0;
        if (m_col == 341) begin
            m_col = 0;
            m_row = (m_row == 261) ? 0 : m_row + 1;
        end else m_col = m_col + 1;
    endtask

    initial begin
        m_col = 0; m_row = 0; m_cnt = 2; m_fint = 1'b0; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state, R1 counters at zero
        check("R9 frame_irq reset", int'(frame_irq), 0);
        check("R9 line_irq reset", int'(line_irq), 0);
        check("R1 reset col", int'(col), 0);
        check("R1 reset row", int'(row), 0);
        rst_n = 1'b1;
        for (int n = 0; n < 2 * 89604 + 40; n++) begin
            bit frame2;
            frame2 = (n >= 89604);
            // Stimulus for the coming edge.
            act_sel   = frame2 ? 2'd1 : ((m_row < 200) ? 2'd0 : 2'd2);
            lint_en   = !(n >= 40000 && n < 50000);
            lint_target = frame2 ? 8'd0 : 8'd2;
            if (frame2) begin fint_row = 9'd10; fint_col = 9'd20; end
            status_rd = (n % 5000 == 17) ||
                        (frame2 && m_col == 20 && m_row == 10);
            lint_ack  = (n % 7000 == 100) || (m_col == 341 && m_row % 9 == 4);
            step_model();
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 195000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule